// File: doc/BRIEF.md
# Auxiliary-Channel Interrupt Status Register

This block holds the interrupt state of an auxiliary-channel controller in one 32-bit word. Six event sources each own three neighbouring bits: a sticky status bit, a write-one-to-clear acknowledge bit one position higher, and an enable bit one position above that. The transfer engine delivers one-cycle event pulses. A status bit captures its pulse and holds it until software acknowledges it.

Software uses a simple register-bus port at word offset 0x20. It reads the word to find out whether a transfer completed or failed. One write can acknowledge any set of sources and rewrite every enable. The block asserts a single registered interrupt line while any captured event is also enabled. Two further outputs report, without masking, whether a completion is pending and whether any error is pending. The error group is every source except completion.

Top module: `aux_irq_status`

## Requirements
- R1: A synchronous active-low reset clears every status bit, every enable bit, the interrupt output and both pending outputs.
- R2: A pulse on event input k sets status bit POS[k] on the next clock edge, with POS = {3, 6, 9, 12, 15, 27} for k = 0 (transfer done), 1 (wrong address), 2 (timeout), 3 (NACK/defer), 4 (wrong data count) and 5 (channel error). The bit stays set until it is acknowledged.
- R3: A write at the register offset with bit POS[k]+1 at 1 clears status k on that edge. With that bit at 0, status k is left as it is.
- R4: When an event pulse and an acknowledge of the same source arrive in the same cycle, the status bit ends up set.
- R5: Every write at the register offset loads enable k from bit POS[k]+2. A write that carries only acknowledge bits therefore clears the enables of those sources.
- R6: A read at the register offset returns status k at bit POS[k] and enable k at bit POS[k]+2. Acknowledge bits and all bits outside the six triplets read 0. Writes to bits outside the triplets have no effect.
- R7: A write to any other address changes nothing. A read of any other address returns 0.
- R8: The interrupt output goes high one cycle after any source has both status and enable set, and goes low one cycle after no source has both.
- R9: done_pending equals status 0. error_pending is the OR of status 1 to 5. Neither depends on the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_pulse | input | 6 | One-cycle event pulses, bit k = source k |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Registered interrupt request |
| done_pending | output | 1 | Transfer-done status, unmasked |
| error_pending | output | 1 | OR of the error statuses, unmasked |

## Verification
Several properties are checked on every cycle. An event always sets its status bit. No status bit rises without an event. Enables change only on a write at the offset. The read word never shows a 1 outside the status and enable positions. The interrupt follows status AND enable with one cycle of delay.

Other behaviours show up only in the bench's scenarios. These are the exact clear-on-acknowledge semantics, the event-over-acknowledge priority, the loss of enables on an acknowledge-only write, and that writes to other addresses are ignored. The bench checks them against a reference model driven by seeded random traffic and directed cases.

// File: rtl/aux_irq_pkg.sv
// Shared constants for the auxiliary-channel interrupt register.
// Assumes six sources in a fixed order: done, wrong address, timeout,
// NACK/defer, wrong data count, channel error.
package aux_irq_pkg;
    localparam int NUM_SRC = 6;
    localparam int WORD_W  = 32;
    localparam int ACK_OFS = 1;
    localparam int EN_OFS  = 2;

    // Bit position of source i's status bit within the word
    function automatic int src_pos(input int i);
        case (i)
            0:       return 3;
            1:       return 6;
            2:       return 9;
            3:       return 12;
            4:       return 15;
            default: return 27;
        endcase
    endfunction
endpackage

// File: rtl/aux_irq_cell.sv
// One source's storage: a sticky status flag and an enable flag.
// Assumes wr_hit is already qualified by address decode. An event
// beats a same-cycle acknowledge.
module aux_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic wr_hit,
    input  logic ack_bit,
    input  logic en_bit,
    output logic stat_q,
    output logic en_q
);
    // Status: set by event, cleared by acknowledge, event has priority
    always_ff @(posedge clk) begin
        if (!rst_n)                 stat_q <= 1'b0;
        else if (evt)               stat_q <= 1'b1;
        else if (wr_hit && ack_bit) stat_q <= 1'b0;
    end

    // Enable: plain storage loaded by every write hit
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= 1'b0;
        else if (wr_hit) en_q <= en_bit;
    end
endmodule

// File: rtl/aux_irq_regif.sv
// Register-bus decode and read-word assembly.
// Assumes single-cycle accesses. Read data is combinational and zero
// when the access misses the offset or is a write.
module aux_irq_regif
    import aux_irq_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h20
) (
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SRC-1:0] stat,
    input  logic [NUM_SRC-1:0] en,
    output logic               wr_hit,
    output logic [WORD_W-1:0]  rdata
);
    logic addr_hit;

    // Address match and write qualification
    always_comb begin
        addr_hit = bus_sel && (bus_addr == REG_OFS);
        wr_hit   = addr_hit && bus_wr;
    end

    // Place each source's status and enable into the read word
    always_comb begin
        rdata = '0;
        if (addr_hit && !bus_wr) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                rdata[src_pos(i)]          = stat[i];
                rdata[src_pos(i) + EN_OFS] = en[i];
            end
        end
    end
endmodule

// File: rtl/aux_irq_status.sv
// Top level: six interrupt cells, bus decode, a registered interrupt
// and unmasked done/error summaries. Assumes event inputs are
// synchronous one-cycle pulses.
module aux_irq_status
    import aux_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [5:0]         evt_pulse,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq,
    output logic               done_pending,
    output logic               error_pending
);
    logic [NUM_SRC-1:0] stat_q;
    logic [NUM_SRC-1:0] en_q;
    logic               wr_hit;

    aux_irq_regif #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_regif (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .stat     (stat_q),
        .en       (en_q),
        .wr_hit   (wr_hit),
        .rdata    (bus_rdata)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        aux_irq_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .evt     (evt_pulse[g]),
            .wr_hit  (wr_hit),
            .ack_bit (bus_wdata[src_pos(g) + ACK_OFS]),
            .en_bit  (bus_wdata[src_pos(g) + EN_OFS]),
            .stat_q  (stat_q[g]),
            .en_q    (en_q[g])
        );
    end

    // Interrupt: registered OR of enabled pending sources
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(stat_q & en_q);
    end

    // Unmasked summaries: completion alone, errors grouped
    always_comb begin
        done_pending  = stat_q[0];
        error_pending = |stat_q[NUM_SRC-1:1];
    end
endmodule

// Assertion checker bound to the top level.
module aux_irq_status_chk
    import aux_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFS = 8'h20
) (
    input logic               clk,
    input logic               rst_n,
    input logic [5:0]         evt_pulse,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic               irq,
    input logic [NUM_SRC-1:0] stat_q,
    input logic [NUM_SRC-1:0] en_q
);
    logic [31:0] legal_mask;
    logic        hit_w;

    always_comb begin
        legal_mask = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            legal_mask[src_pos(i)]          = 1'b1;
            legal_mask[src_pos(i) + EN_OFS] = 1'b1;
        end
        hit_w = bus_sel && bus_wr && (bus_addr == REG_OFS);
    end

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pulse != 0) |=> ((stat_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(evt_pulse)) == 0));

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_w |=> $stable(en_q));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) != 0) |=> irq);

    // R8
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & en_q) == 0) |=> !irq);

    // R6
    always_comb begin
        if (rst_n) begin
            rdata_mask_chk: assert ((bus_rdata & ~legal_mask) == 0);
        end
    end
endmodule

bind aux_irq_status aux_irq_status_chk #(.ADDR_W(ADDR_W), .REG_OFS(REG_OFS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .stat_q    (stat_q),
    .en_q      (en_q)
);

// File: tb/test_aux_irq_status.sv
// Self-checking bench: seeded random traffic plus directed corner cases
// against a bench-side reference model.
module test_aux_irq_status;
    localparam int  CLK_NS = 8;
    localparam int  NSRC   = 6;
    localparam int  POS [NSRC] = '{3, 6, 9, 12, 15, 27};
    localparam logic [7:0] OFS = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  evt_pulse = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, done_pending, error_pending;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [5:0] m_stat = '0, m_en = '0;
    logic       m_irq = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    aux_irq_status i_aux_irq_status (
        .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
        .done_pending(done_pending), .error_pending(error_pending)
    );

    function automatic logic [31:0] pack_word(logic [5:0] s, logic [5:0] e);
        logic [31:0] w = '0;
        for (int i = 0; i < NSRC; i++) begin
            w[POS[i]]   = s[i];
            w[POS[i]+2] = e[i];
        end
        return w;
    endfunction

    function automatic logic [5:0] next_stat(logic [5:0] s, logic [5:0] ev,
                                             logic hit, logic [31:0] wd);
        logic [5:0] n = s;
        for (int i = 0; i < NSRC; i++) begin
            if (ev[i])                  n[i] = 1'b1;
            else if (hit && wd[POS[i]+1]) n[i] = 1'b0;
        end
        return n;
    endfunction

    function automatic logic [5:0] next_en(logic [5:0] e, logic hit, logic [31:0] wd);
        logic [5:0] n = e;
        if (hit) for (int i = 0; i < NSRC; i++) n[i] = wd[POS[i]+2];
        return n;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model at posedge, check at next negedge
    task automatic step(logic [5:0] ev, logic wr, logic [7:0] addr, logic [31:0] wd);
        logic hit;
        evt_pulse = ev; bus_sel = wr; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        hit = wr && (addr == OFS);
        @(posedge clk);
        m_irq  = |(m_stat & m_en);
        m_stat = next_stat(m_stat, ev, hit, wd);
        m_en   = next_en(m_en, hit, wd);
        @(negedge clk);
        evt_pulse = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        check("R8 irq", {31'b0, irq}, {31'b0, m_irq});
        check("R9 done_pending", {31'b0, done_pending}, {31'b0, m_stat[0]});
        check("R9 error_pending", {31'b0, error_pending}, {31'b0, |m_stat[5:1]});
    endtask

    task automatic rd(string req, logic [7:0] addr, logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
        #1;
        check(req, bus_rdata, exp);
        bus_sel = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1: reset state
        rst_n = 1'b1;
        rd("R1 reset word", OFS, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 pending", {30'b0, done_pending, error_pending}, 32'h0);

        // R2: each event sets its own bit
        for (int i = 0; i < NSRC; i++) step(6'(1 << i), 1'b0, OFS, '0);
        rd("R2 all set", OFS, pack_word(6'h3f, 6'h0));
        // R3: acknowledge sources 1 and 4 only, enables stay clear
        step('0, 1'b1, OFS, (32'h1 << (POS[1]+1)) | (32'h1 << (POS[4]+1)));
        rd("R3 partial ack", OFS, pack_word(6'h2d, 6'h0));
        // R5/R8: enable source 5, irq follows one cycle later
        step('0, 1'b1, OFS, 32'h1 << (POS[5]+2));
        rd("R5 enable set", OFS, pack_word(6'h2d, 6'h20));
        step('0, 1'b0, OFS, '0);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        // R5: ack-only write clears enable; R3 clear
        step('0, 1'b1, OFS, 32'h1 << (POS[5]+1));
        rd("R5 ack-only clears enable", OFS, pack_word(6'h0d, 6'h0));
        // R4: event and ack in the same cycle
        step(6'h01, 1'b1, OFS, 32'h1 << (POS[0]+1));
        rd("R4 event wins", OFS, pack_word(6'h0d, 6'h0));
        // R7: other address write ignored, read returns 0
        step('0, 1'b1, 8'h24, 32'hffff_ffff);
        rd("R7 other addr write", OFS, pack_word(6'h0d, 6'h0));
        rd("R7 other addr read", 8'h24, 32'h0);
        // R6: reserved and ack bits read 0 after an all-ones write
        step('0, 1'b1, OFS, 32'hffff_ffff);
        rd("R6 ack and reserved read 0", OFS, pack_word(6'h00, 6'h3f));

        // Random traffic
        for (int n = 0; n < 2000; n++) begin
            logic [5:0]  ev;
            logic        wr;
            logic [7:0]  ad;
            logic [31:0] wd;
            ev = ($urandom % 4 == 0) ? 6'($urandom) : 6'h0;
            wr = ($urandom % 3 == 0);
            ad = ($urandom % 8 == 0) ? 8'($urandom) : OFS;
            wd = $urandom;
            step(ev, wr, ad, wd);
            if (n % 5 == 0) rd("R2 R3 R5 R6 random read", OFS, pack_word(m_stat, m_en));
        end

        // R1: reset mid-run clears everything
        step(6'h3f, 1'b1, OFS, 32'hffff_ffff);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        m_stat = '0; m_en = '0;
        rd("R1 reset after traffic", OFS, 32'h0);
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule